// File: doc/BRIEF.md
# Window Watchdog Supervisor with Pin-Selected Timing

This block drives an active-low system reset from two sources: a supply-good input and a window watchdog. While supply-good is low the reset output stays asserted. When supply-good rises, a fixed release delay runs, and the reset output then deasserts. From that point software must toggle the kick input so that each rising edge lands inside a timing window. An edge that comes too soon, or no edge before the window closes, asserts reset again for another full release delay.

Two select pins choose one of three windows or switch the watchdog off. A pin value counts only after it has stayed unchanged for a settle interval. The window is captured only at reset release. Turning the watchdog off and then on again through the pins brings back the window captured at the last release. A new window selection takes effect only after the next release. All durations are counts of an external tick enable, so the same logic serves any time base.

Top module: `wdt_window_supervisor`

## Requirements
- R1: While rst_n is low or supply_ok is low, rst_out_n is 0. After supply_ok rises, rst_out_n stays 0 for RST_DLY ticks and then goes to 1.
- R2: Kick edges that arrive while rst_out_n is 0 are not counted, and they do not cause a fault after release.
- R3: The select code is {sel_hi, sel_lo}. 00 selects the fast window (FAST_LO, FAST_HI), 11 selects the slow window (SLOW_LO, SLOW_HI), 10 selects the middle window (MID_LO, MID_HI), and 01 disables the watchdog.
- R4: The window is captured from the settled select code when rst_out_n rises, and it stays fixed while rst_out_n is 1.
- R5: A rising kick edge that arrives at least LO ticks and fewer than HI ticks after the window started is accepted. rst_out_n stays 1 and the window restarts from zero.
- R6: A rising kick edge that arrives fewer than LO ticks after the window started asserts rst_out_n = 0 for a full RST_DLY ticks.
- R7: If no kick edge arrives within HI ticks of the window start, rst_out_n goes to 0 for a full RST_DLY ticks.
- R8: While the settled code is 01, the watchdog does not time out and rst_out_n stays 1.
- R9: When the code leaves 01 without an intervening reset, the watchdog uses the window captured at the last release, not the newly selected one.
- R10: A new select code is used only after it has stayed unchanged for SETTLE ticks. A shorter change has no effect.
- R11: When supply_ok falls, rst_out_n goes to 0 on the next clock. The release delay restarts when supply_ok rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| tick | input | 1 | Time-base enable, one pulse per timing unit |
| supply_ok | input | 1 | Supply-good indication, high when the supply is valid |
| sel_lo | input | 1 | Window select pin, low bit of the code |
| sel_hi | input | 1 | Window select pin, high bit of the code |
| kick | input | 1 | Watchdog service input; its rising edges are counted |
| rst_out_n | output | 1 | Active-low system reset |

## Verification
The bench tells the windows apart by their effect. A kick that one window accepts is chosen to be early or late under another window, so a wrong decode or a wrong latch moment shows up as an unexpected reset or a missing one. The re-enable case switches from disabled to a slower code and then kicks at a time valid only for the old fast window. A design that latched the new window there would reset at once. A select glitch shorter than the settle interval is placed right after a valid kick. If the design took the glitch, it would clear the window and delay the timeout beyond the point where the bench expects reset. Kicks during the release delay check that stale edges raise no early fault, and a supply drop checks that reset asserts within one clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // Select code, formed as {sel_hi, sel_lo}
  typedef enum logic [1:0] {
    CFG_FAST = 2'b00,
    CFG_OFF  = 2'b01,
    CFG_MID  = 2'b10,
    CFG_SLOW = 2'b11
  } cfg_code_e;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'b00,
    ST_DELAY = 2'b01,
    ST_RUN   = 2'b10
  } sup_state_e;

endpackage

// File: rtl/wdt_cfg_filter.sv
module wdt_cfg_filter
  import wdt_pkg::*;
#(
  parameter int SETTLE = 5
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      sel_lo,
  input  logic      sel_hi,
  output cfg_code_e cfg
);

  localparam int SET_W = $clog2(SETTLE + 1);

  logic [1:0] sync1_q, sync2_q;
  cfg_code_e  cand_q, cand_d;
  cfg_code_e  cfg_q, cfg_d;
  logic [SET_W-1:0] cnt_q, cnt_d;

  // Next-state: restart on any pin change, adopt after SETTLE stable ticks
  always_comb begin
    cand_d = cand_q;
    cfg_d  = cfg_q;
    cnt_d  = cnt_q;
    if (cfg_code_e'(sync2_q) != cand_q) begin
      cand_d = cfg_code_e'(sync2_q);
      cnt_d  = '0;
    end else if (cand_q != cfg_q && tick) begin
      if (cnt_q == SET_W'(SETTLE - 1)) begin
        cfg_d = cand_q;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 2'b00;
      sync2_q <= 2'b00;
      cand_q  <= CFG_FAST;
      cfg_q   <= CFG_FAST;
      cnt_q   <= '0;
    end else begin
      sync1_q <= {sel_hi, sel_lo};
      sync2_q <= sync1_q;
      cand_q  <= cand_d;
      cfg_q   <= cfg_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cfg = cfg_q;

  // R10: the settled code moves only on a tick that ends a full settle run
  assert_settle_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> ($past(tick) && $past(cnt_q) == SET_W'(SETTLE - 1)));

  // R10: the settled code only ever takes the value of the candidate
  assert_settle_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q != $past(cfg_q)) |-> (cfg_q == $past(cand_q)));

endmodule

// File: rtl/wdt_rst_seq.sv
module wdt_rst_seq
  import wdt_pkg::*;
#(
  parameter int RST_DLY = 2000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      supply_ok,
  input  logic      fault,
  input  cfg_code_e cfg,
  output logic      run,
  output cfg_code_e win_sel
);

  localparam int DLY_W = $clog2(RST_DLY + 1);

  sup_state_e       state_q, state_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  cfg_code_e        win_q, win_d;
  logic             release_now;

  assign release_now = (state_q == ST_DELAY) && supply_ok && tick &&
                       (dly_q == DLY_W'(RST_DLY - 1));

  always_comb begin
    state_d = state_q;
    dly_d   = dly_q;
    win_d   = win_q;
    unique case (state_q)
      ST_HOLD: begin
        dly_d = '0;
        if (supply_ok) state_d = ST_DELAY;
      end
      ST_DELAY: begin
        if (!supply_ok) begin
          state_d = ST_HOLD;
          dly_d   = '0;
        end else if (release_now) begin
          state_d = ST_RUN;
          dly_d   = '0;
          if (cfg != CFG_OFF) win_d = cfg;
        end else if (tick) begin
          dly_d = dly_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (!supply_ok) begin
          state_d = ST_HOLD;
        end else if (fault) begin
          state_d = ST_DELAY;
          dly_d   = '0;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      dly_q   <= '0;
      win_q   <= CFG_FAST;
    end else begin
      state_q <= state_d;
      dly_q   <= dly_d;
      win_q   <= win_d;
    end
  end

  assign run     = (state_q == ST_RUN);
  assign win_sel = win_q;

  // R11: a supply drop forces reset on the next clock
  assert_supply_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state_q == ST_HOLD));

  // R6: a fault while running restarts the full release delay
  assert_fault_delay_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && supply_ok && fault) |=> (state_q == ST_DELAY && dly_q == '0));

  // R4: the captured window never moves while running
  assert_window_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |=> (state_q != ST_RUN || $stable(win_q)));

  // R1: release happens only from the delay state
  assert_release_path_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> ($past(state_q) == ST_DELAY && $past(tick)));

endmodule

// File: rtl/wdt_win_mon.sv
module wdt_win_mon #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             en,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  input  logic             kick,
  output logic             fault
);

  logic [2:0]       ksh_q;
  logic             kedge, active, early, late;
  logic [CNT_W-1:0] cnt_q, cnt_d, hi_m1;

  assign kedge  = ksh_q[1] & ~ksh_q[2];
  assign active = run & en;
  assign hi_m1  = hi - 1'b1;
  assign early  = active & kedge & (cnt_q < lo);
  assign late   = active & tick & ~kedge & (cnt_q >= hi_m1);
  assign fault  = early | late;

  always_comb begin
    cnt_d = cnt_q;
    if (!active || kedge) begin
      cnt_d = '0;
    end else if (tick && cnt_q < hi_m1) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ksh_q <= 3'b000;
      cnt_q <= '0;
    end else begin
      ksh_q <= {ksh_q[1:0], kick};
      cnt_q <= cnt_d;
    end
  end

  // R7: the elapsed count never reaches the upper bound
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt_q < hi));

  // R2: nothing is counted outside the running state
  assert_idle_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  // R5: an accepted edge restarts the window
  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kedge && !early) |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_window_supervisor.sv
module wdt_window_supervisor
  import wdt_pkg::*;
#(
  parameter int RST_DLY = 2000,
  parameter int SETTLE  = 5,
  parameter int FAST_LO = 225,
  parameter int FAST_HI = 550,
  parameter int MID_LO  = 2000,
  parameter int MID_HI  = 4000,
  parameter int SLOW_LO = 8000,
  parameter int SLOW_HI = 16000,
  parameter int CNT_W   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok,
  input  logic sel_lo,
  input  logic sel_hi,
  input  logic kick,
  output logic rst_out_n
);

  cfg_code_e        cfg, win_sel;
  logic             run, fault, wd_en;
  logic [CNT_W-1:0] lo, hi;

  wdt_cfg_filter #(.SETTLE(SETTLE)) u_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .sel_lo (sel_lo),
    .sel_hi (sel_hi),
    .cfg    (cfg)
  );

  wdt_rst_seq #(.RST_DLY(RST_DLY)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .supply_ok (supply_ok),
    .fault     (fault),
    .cfg       (cfg),
    .run       (run),
    .win_sel   (win_sel)
  );

  always_comb begin
    unique case (win_sel)
      CFG_SLOW: begin lo = CNT_W'(SLOW_LO); hi = CNT_W'(SLOW_HI); end
      CFG_MID:  begin lo = CNT_W'(MID_LO);  hi = CNT_W'(MID_HI);  end
      default:  begin lo = CNT_W'(FAST_LO); hi = CNT_W'(FAST_HI); end
    endcase
  end

  assign wd_en = (cfg != CFG_OFF);

  wdt_win_mon #(.CNT_W(CNT_W)) u_mon (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .run   (run),
    .en    (wd_en),
    .lo    (lo),
    .hi    (hi),
    .kick  (kick),
    .fault (fault)
  );

  assign rst_out_n = run;

  // R8: with the watchdog switched off, no fault is raised
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg == CFG_OFF) |-> !fault);

endmodule

// File: tb/wdt_window_supervisor_tb.sv
module wdt_window_supervisor_tb;

  logic clk, rst_n, tick, supply_ok, sel_lo, sel_hi, kick;
  logic rst_out_n;
  int   n_cmp, n_bad;
  bit   done;

  wdt_window_supervisor #(
    .RST_DLY(20), .SETTLE(4),
    .FAST_LO(3),  .FAST_HI(8),
    .MID_LO(5),   .MID_HI(16),
    .SLOW_LO(10), .SLOW_HI(25),
    .CNT_W(8)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .supply_ok(supply_ok),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .kick(kick), .rst_out_n(rst_out_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    tick = 1'b0;
    forever begin
      repeat (3) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rst_out_n actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) @(negedge clk);
  endtask

  task automatic pulse_kick();
    @(negedge clk) kick = 1'b1;
    repeat (2) @(negedge clk);
    kick = 1'b0;
  endtask

  task automatic wait_release(input string req);
    int i;
    for (i = 0; i < 400 && rst_out_n !== 1'b1; i++) @(negedge clk);
    if (rst_out_n !== 1'b1) check(req, rst_out_n, 1'b1);
  endtask

  task automatic t_reset_state();
    wait_ticks(3);
    check("R1 reset state", rst_out_n, 1'b0);
  endtask

  task automatic t_power_up();
    @(negedge clk) supply_ok = 1'b1;
    wait_ticks(8);
    pulse_kick();               // R2: edges during delay are ignored
    wait_ticks(4);
    pulse_kick();
    wait_ticks(5);
    check("R1 still held in delay", rst_out_n, 1'b0);
    wait_ticks(6);
    check("R1 released after delay", rst_out_n, 1'b1);
    wait_ticks(1);
    check("R2 no stale edge fault", rst_out_n, 1'b1);
    pulse_kick();
  endtask

  task automatic t_pet_ok();
    for (int k = 0; k < 5; k++) begin
      wait_ticks(5);
      pulse_kick();
      wait_ticks(1);
      check("R5 kick inside fast window", rst_out_n, 1'b1);
      wait_ticks(-1 + 1);
    end
  endtask

  task automatic t_timeout();
    wait_ticks(5);
    check("R7 before upper bound", rst_out_n, 1'b1);
    wait_ticks(5);
    check("R7 timeout reset", rst_out_n, 1'b0);
    wait_ticks(15);
    check("R7 reset held full delay", rst_out_n, 1'b0);
    wait_release("R7 release after timeout");
  endtask

  task automatic t_early();
    wait_ticks(5);
    pulse_kick();
    wait_ticks(1);
    pulse_kick();
    wait_ticks(1);
    check("R6 early kick reset", rst_out_n, 1'b0);
    wait_ticks(16);
    check("R6 reset held full delay", rst_out_n, 1'b0);
    wait_release("R6 release after early fault");
  endtask

  task automatic t_disable();
    wait_ticks(5);
    pulse_kick();
    sel_lo = 1'b1; sel_hi = 1'b0;          // code 01: off
    for (int k = 0; k < 4; k++) begin
      wait_ticks(10);
      check("R8 disabled no timeout", rst_out_n, 1'b1);
    end
  endtask

  task automatic t_reenable();
    sel_hi = 1'b1;                          // code 11 selected, fast still latched
    wait_ticks(9);
    pulse_kick();
    wait_ticks(1);
    check("R9 old fast window accepts kick", rst_out_n, 1'b1);
    wait_ticks(11);
    check("R9 old fast window times out", rst_out_n, 1'b0);
    wait_release("R9 release");
  endtask

  task automatic t_latch_slow();
    wait_ticks(15);
    pulse_kick();
    wait_ticks(12);
    check("R4 slow window latched at release", rst_out_n, 1'b1);
    wait_ticks(3);
    pulse_kick();
    wait_ticks(1);
    check("R4 slow window kick accepted", rst_out_n, 1'b1);
  endtask

  task automatic t_glitch();
    sel_hi = 1'b0;                          // brief code 01
    wait_ticks(2);
    sel_hi = 1'b1;
    wait_ticks(17);
    check("R10 short glitch, still running", rst_out_n, 1'b1);
    wait_ticks(9);
    check("R10 short glitch ignored, timeout", rst_out_n, 1'b0);
  endtask

  task automatic t_mid();
    sel_lo = 1'b0; sel_hi = 1'b1;           // code 10 during delay
    wait_release("R3 release");
    wait_ticks(11);
    pulse_kick();
    wait_ticks(2);
    check("R3 middle window accepts kick", rst_out_n, 1'b1);
    wait_ticks(16);
    check("R3 middle window times out", rst_out_n, 1'b0);
    wait_release("R3 release after timeout");
  endtask

  task automatic t_supply();
    wait_ticks(3);
    @(negedge clk) supply_ok = 1'b0;
    @(negedge clk);
    check("R11 reset on supply drop", rst_out_n, 1'b0);
    wait_ticks(10);
    check("R11 held while supply low", rst_out_n, 1'b0);
    supply_ok = 1'b1;
    wait_ticks(17);
    check("R11 delay restarted", rst_out_n, 1'b0);
    wait_ticks(6);
    check("R11 released after delay", rst_out_n, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; supply_ok = 1'b0;
    sel_lo = 1'b0; sel_hi = 1'b0; kick = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_power_up();
    t_pet_ok();
    t_timeout();
    t_early();
    t_disable();
    t_reenable();
    t_latch_slow();
    t_glitch();
    t_mid();
    t_supply();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule